// File: doc/BRIEF.md
# Serial-Addressed Multichannel DAC Register Bank

This block is the digital front end of a 6-bit multichannel DAC controller. A host sends 12-bit command frames over three wires: a data line, a shift clock and a load strobe. Each rising shift clock edge moves one bit into a 12-bit shift register. A rising load edge then decodes the top four bits as a channel address. The six low bits are written into the holding latch of that channel. Two side-band bits go to general-purpose option pins. The oldest stage of the shift register is always presented on a cascade output, so several identical blocks can share one data line as a daisy chain.

The whole block runs on one system clock. The three serial wires are treated as asynchronous: each passes through a two-flop synchronizer, and rising edges on the synchronized shift clock and load strobe become single-cycle strobes. A parameter chooses an 8-channel build or a 4-channel build. Only the 4-channel build has the second option pin. The analog ladder that turns a stored code n into a level of (n+1)/64 of the reference lies outside this block.

Top module: `dac_serial_bank`

## Requirements
- R1: After reset, every channel code, both option pins, the cascade output and the load pulse are 0.
- R2: Each shift clock rising edge shifts the synchronized data bit into bit 0 of the 12-bit shift register, and the older contents move up by one place. A frame is therefore sent most significant bit (bit 11) first. A shift clock held high for many system cycles causes exactly one shift.
- R3: A load strobe rising edge with address field bits[11:8] = k, where 1 <= k <= NUM_CH, writes bits[5:0] into channel k. Channel k sits at dac_codes[(k-1)*6 +: 6]. No other channel changes.
- R4: Address 0 and addresses 9 to 15 change no channel.
- R5: With NUM_CH = 4, addresses 5 to 8 also change no channel.
- R6: Every load strobe latches bit 6 onto opt_out1, whatever the address, including ignored ones. With NUM_CH = 4 it also latches bit 7 onto opt_out2. With NUM_CH = 8, opt_out2 stays 0.
- R7: cascade_out always equals bit 11 of the shift register. It changes only on a shift.
- R8: A synchronous reset in the middle of operation clears all channels, both option pins and the shift register.
- R9: For every load strobe, load_pulse is high for exactly one cycle, in the same cycle the new latch values appear. load_chan then gives the written channel number (1..NUM_CH), or 0 when the address was ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data, asynchronous |
| ser_sck | input | 1 | Serial shift clock, asynchronous |
| ser_ld | input | 1 | Load strobe, asynchronous |
| dac_codes | output | NUM_CH*6 | Held 6-bit code of every channel, channel 1 in the low bits |
| opt_out1 | output | 1 | Option pin driven by frame bit 6 |
| opt_out2 | output | 1 | Option pin driven by frame bit 7 (4-channel build only) |
| cascade_out | output | 1 | Last shift register stage, for chaining |
| load_pulse | output | 1 | One-cycle pulse after each load |
| load_chan | output | 4 | Channel written by that load, 0 if ignored |

## Verification
Frames are sent to an 8-channel and a 4-channel instance wired in parallel, and each load is checked against the whole code vector. The sequence covers these cases:
- Single-channel writes at the first and last valid addresses, which catch slice and off-by-one errors.
- A sweep of all eight addresses with distinct codes, which catches crossed channel decodes.
- Addresses 5 to 8, which separate the two builds.
- Addresses 0, 9 and 15, which must leave every channel alone while the option pins still update.
- A repeated load with no new shift, and a reset in mid-run.

The cascade output is compared after every single shift against the bit sent twelve shifts earlier, which exposes errors in bit order and shift length.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int FRAME_W = 12;
  localparam int CODE_W  = 6;
  localparam int ADDR_W  = 4;

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FRAME_W-1:0] f);
    return f[11:8];
  endfunction

  function automatic logic [CODE_W-1:0] frame_code(input logic [FRAME_W-1:0] f);
    return f[5:0];
  endfunction

  function automatic logic frame_opt_a(input logic [FRAME_W-1:0] f);
    return f[6];
  endfunction

  function automatic logic frame_opt_b(input logic [FRAME_W-1:0] f);
    return f[7];
  endfunction

  // channel number 1..nch for a valid address, 0 for an ignored one
  function automatic logic [ADDR_W-1:0] chan_of(input logic [ADDR_W-1:0] a, input int nch);
    return (a != '0 && int'(a) <= nch) ? a : '0;
  endfunction
endpackage

// File: rtl/dsb_sync.sv
module dsb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
  assign rise     = sync_out & ~prev_q;
endmodule

// File: rtl/dsb_shifter.sv
module dsb_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] frame_q,
  output logic         tail
);
  always_ff @(posedge clk) begin
    if (rst)           frame_q <= '0;
    else if (shift_en) frame_q <= {frame_q[W-2:0], din};
  end

  assign tail = frame_q[W-1];

  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> frame_q == {$past(frame_q[W-2:0]), $past(din)});
  // R7
  tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(tail));
endmodule

// File: rtl/dsb_latch_bank.sv
module dsb_latch_bank
  import dsb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CW     = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_en,
  input  logic [FRAME_W-1:0]   frame,
  output logic [NUM_CH*CW-1:0] codes,
  output logic                 opt_a,
  output logic                 opt_b,
  output logic                 done_pulse,
  output logic [ADDR_W-1:0]    done_chan
);
  logic [ADDR_W-1:0] chan;
  logic [NUM_CH-1:0] wr_sel;
  logic [CW-1:0]     code_q [NUM_CH];

  assign chan = chan_of(frame_addr(frame), NUM_CH);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_sel[i] = load_en && (chan == ADDR_W'(i + 1));
    always_ff @(posedge clk) begin
      if (rst)            code_q[i] <= '0;
      else if (wr_sel[i]) code_q[i] <= frame_code(frame);
    end
    assign codes[i*CW +: CW] = code_q[i];

    // R3
    ch_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_sel[i] |=> code_q[i] == $past(frame_code(frame)));
    // R4
    ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[i] |=> $stable(code_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_a      <= 1'b0;
      done_pulse <= 1'b0;
      done_chan  <= '0;
    end else begin
      done_pulse <= load_en;
      done_chan  <= load_en ? chan : '0;
      if (load_en) opt_a <= frame_opt_a(frame);
    end
  end

  if (NUM_CH <= 4) begin : g_opt_b
    always_ff @(posedge clk) begin
      if (rst)          opt_b <= 1'b0;
      else if (load_en) opt_b <= frame_opt_b(frame);
    end
  end else begin : g_no_opt_b
    assign opt_b = 1'b0;
  end

  // R6
  opt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> opt_a == $past(frame_opt_a(frame)));
  // R9
  pulse_follow_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> done_pulse);
  // R9
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> !done_pulse);
  // R9
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> int'(done_chan) <= NUM_CH);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (codes == '0 && !opt_a && !opt_b && !done_pulse));
endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank
  import dsb_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_din,
  input  logic                     ser_sck,
  input  logic                     ser_ld,
  output logic [NUM_CH*CODE_W-1:0] dac_codes,
  output logic                     opt_out1,
  output logic                     opt_out2,
  output logic                     cascade_out,
  output logic                     load_pulse,
  output logic [ADDR_W-1:0]        load_chan
);
  localparam int IDX_DIN = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_LD  = 2;

  logic [2:0]         wires_sync;
  logic [2:0]         wires_rise;
  logic               shift_stb;
  logic               load_stb;
  logic [FRAME_W-1:0] frame_q;

  dsb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_ld, ser_sck, ser_din}),
    .sync_out (wires_sync),
    .rise     (wires_rise)
  );

  assign shift_stb = wires_rise[IDX_SCK];
  assign load_stb  = wires_rise[IDX_LD];

  dsb_shifter #(.W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_stb),
    .din      (wires_sync[IDX_DIN]),
    .frame_q  (frame_q),
    .tail     (cascade_out)
  );

  dsb_latch_bank #(.NUM_CH(NUM_CH), .CW(CODE_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_stb),
    .frame      (frame_q),
    .codes      (dac_codes),
    .opt_a      (opt_out1),
    .opt_b      (opt_out2),
    .done_pulse (load_pulse),
    .done_chan  (load_chan)
  );

  // R2
  shift_single_chk: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> !shift_stb);
  // R9
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);
  // R6
  opt2_absent_chk: assert property (@(posedge clk) disable iff (rst)
    (NUM_CH > 4) |-> !opt_out2);
endmodule

// File: tb/sim_dac_serial_bank.sv
module sim_dac_serial_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_din = 1'b0, ser_sck = 1'b0, ser_ld = 1'b0;
  always #2 clk = ~clk;

  logic [47:0] codes0;  logic o1_0, o2_0, cas0, lp0;  logic [3:0] lc0;
  logic [23:0] codes1;  logic o1_1, o2_1, cas1, lp1;  logic [3:0] lc1;

  dac_serial_bank #(.NUM_CH(8)) u0 (.clk(clk), .rst(rst), .ser_din(ser_din), .ser_sck(ser_sck),
    .ser_ld(ser_ld), .dac_codes(codes0), .opt_out1(o1_0), .opt_out2(o2_0), .cascade_out(cas0),
    .load_pulse(lp0), .load_chan(lc0));
  dac_serial_bank #(.NUM_CH(4)) u1 (.clk(clk), .rst(rst), .ser_din(ser_din), .ser_sck(ser_sck),
    .ser_ld(ser_ld), .dac_codes(codes1), .opt_out1(o1_1), .opt_out2(o2_1), .cascade_out(cas1),
    .load_pulse(lp1), .load_chan(lc1));

  int checks = 0, fails = 0;
  logic [11:0] m_sh = '0;
  logic [47:0] m8 = '0;
  logic [23:0] m4 = '0;

  typedef struct {
    logic [3:0] ch8; logic [47:0] v8; logic [3:0] ch4; logic [23:0] v4; logic o1; logic o2;
  } exp_t;
  exp_t q[$];
  exp_t mon_e;
  logic prev_lp = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk) ser_din = b;
    repeat (3) @(negedge clk);
    ser_sck = 1'b1;
    repeat (5) @(negedge clk);
    ser_sck = 1'b0;
    repeat (5) @(negedge clk);
    m_sh = {m_sh[10:0], b};
    chk("R7", "cascade 8ch", {63'd0, cas0}, {63'd0, m_sh[11]});
    chk("R2", "cascade 4ch", {63'd0, cas1}, {63'd0, m_sh[11]});
  endtask

  task automatic shift_frame(input logic [3:0] addr, input logic b7, input logic b6, input logic [5:0] code);
    logic [11:0] f;
    f = {addr, b7, b6, code};
    for (int i = 11; i >= 0; i--) shift_bit(f[i]);
  endtask

  task automatic do_load();
    exp_t e;
    logic [3:0] a;
    a = m_sh[11:8];
    e.ch8 = (a >= 4'd1 && a <= 4'd8) ? a : 4'd0;
    e.ch4 = (a >= 4'd1 && a <= 4'd4) ? a : 4'd0;
    if (e.ch8 != 0) m8[(int'(e.ch8) - 1) * 6 +: 6] = m_sh[5:0];
    if (e.ch4 != 0) m4[(int'(e.ch4) - 1) * 6 +: 6] = m_sh[5:0];
    e.v8 = m8; e.v4 = m4; e.o1 = m_sh[6]; e.o2 = m_sh[7];
    q.push_back(e);
    @(negedge clk) ser_ld = 1'b1;
    repeat (5) @(negedge clk);
    ser_ld = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9", "pending loads", 64'(q.size()), 64'd0);
  endtask

  task automatic check_zero(input string req);
    chk(req, "codes 8ch", {16'd0, codes0}, 64'd0);
    chk(req, "codes 4ch", {40'd0, codes1}, 64'd0);
    chk(req, "opts", {60'd0, o1_0, o2_0, o1_1, o2_1}, 64'd0);
    chk(req, "cascade", {62'd0, cas0, cas1}, 64'd0);
    chk(req, "load pulse", {62'd0, lp0, lp1}, 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (lp0 || lp1) begin
        if (q.size() == 0) begin
          chk("R9", "unexpected load pulse", {62'd0, lp0, lp1}, 64'd0);
        end else begin
          mon_e = q.pop_front();
          chk("R9", "pulse pair", {62'd0, lp0, lp1}, 64'd3);
          chk("R9", "load_chan 8ch", {60'd0, lc0}, {60'd0, mon_e.ch8});
          chk("R9", "load_chan 4ch", {60'd0, lc1}, {60'd0, mon_e.ch4});
          chk(mon_e.ch8 == 0 ? "R4" : "R3", "codes 8ch", {16'd0, codes0}, {16'd0, mon_e.v8});
          chk(mon_e.ch4 == 0 ? "R5" : "R3", "codes 4ch", {40'd0, codes1}, {40'd0, mon_e.v4});
          chk("R6", "opt1 8ch", {63'd0, o1_0}, {63'd0, mon_e.o1});
          chk("R6", "opt1 4ch", {63'd0, o1_1}, {63'd0, mon_e.o1});
          chk("R6", "opt2 8ch absent", {63'd0, o2_0}, 64'd0);
          chk("R6", "opt2 4ch", {63'd0, o2_1}, {63'd0, mon_e.o2});
        end
        if (prev_lp) chk("R9", "pulse longer than one cycle", 64'd1, 64'd0);
      end
      prev_lp = lp0 || lp1;
    end else begin
      prev_lp = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_zero("R1");
    shift_frame(4'd1, 1'b0, 1'b1, 6'h2A); do_load();   // R3 first channel, opt1 high
    shift_frame(4'd4, 1'b1, 1'b0, 6'h3F); do_load();   // R3 last channel of 4ch build, opt2 high
    shift_frame(4'd5, 1'b1, 1'b1, 6'h05); do_load();   // R5 ignored by 4ch build
    shift_frame(4'd8, 1'b0, 1'b0, 6'h15); do_load();   // R5 / R3 top channel of 8ch build
    shift_frame(4'd0, 1'b1, 1'b1, 6'h07); do_load();   // R4 address 0, R6 opts still latch
    shift_frame(4'd9, 1'b0, 1'b1, 6'h3E); do_load();   // R4 address 9
    shift_frame(4'd15, 1'b1, 1'b0, 6'h01); do_load();  // R4 address 15
    for (int c = 1; c <= 8; c++) begin                 // R3 sweep
      shift_frame(4'(c), c[0], c[1], 6'(c * 7));
      do_load();
    end
    do_load();                                         // R9 repeated load without shift
    shift_frame(4'd2, 1'b0, 1'b0, 6'h00); do_load();   // R3 code zero
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_sh = '0; m8 = '0; m4 = '0;
    @(negedge clk);
    check_zero("R8");
    shift_frame(4'd3, 1'b1, 1'b1, 6'h33); do_load();   // R8 operation resumes after reset
    repeat (4) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule